// File: doc/BRIEF.md
# Two-Wire ADC Readout and Mode Controller

This block is the device-side digital controller of a converter that talks to its host over two pins: a serial clock input driven by the host and a single output line that shows both readiness and data. The converter core hands over each finished result with a one-cycle done pulse. The controller holds the result and pulls the line low to say a result is waiting. It then shifts the word out, most significant bit first, one bit for each host clock pulse.

Every host command is carried by the host clock. Pulses beyond the data bits are counted: the 25th pulse returns the line high, and the falling edge of the 26th pulse asks the core for a self-calibration. A host clock held high for longer than a set number of system clocks while a result is pending puts the core to sleep. Pulling the host clock low again wakes the core, with a plain conversion or, when the sleep began on the 26th pulse, a calibration. One self-calibration request is made after reset. The host clock is asynchronous. It passes through a two-flop synchroniser, and its edges are found in the system clock domain.

Top module: `twr_readout_top`

## Requirements
- R1: While reset is held, the line is high and all three core controls are low. After reset is released, exactly one calibration request pulse is issued. The line stays high until the first result arrives.
- R2: A done pulse from the core latches the result and drives the line low. The line stays low until the first host clock pulse.
- R3: Host rising edges 1 to 18 present result bits 17 down to 0 in turn, most significant first. The word is passed unchanged, in two's complement.
- R4: Rising edges 19 to 24 leave the line at the value of bit 0. With no further pulse, the line keeps the last bit shifted.
- R5: The 25th rising edge drives the line high.
- R6: The falling edge of the 26th pulse issues one calibration request pulse. The line then stays high, and host pulses have no effect, until the next result arrives.
- R7: A result that arrives before the current one has been fully released replaces it. The frame restarts: the line goes low and the next pulses shift the new word from bit 17.
- R8: If the host clock stays high for HOLD_CYC system clocks while a result is pending, the sleep output rises and the line is driven high. A result that arrives during sleep has no effect on the line.
- R9: A host clock falling edge during sleep clears the sleep output and issues one conversion request pulse. The line stays high until the next result.
- R10: If sleep began while the 26th pulse was held high, waking issues a calibration request pulse instead of a conversion request pulse.
- R11: A long host clock high period while no result is pending does not cause sleep.
- R12: Calibration and conversion requests are single-cycle pulses and never occur in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least four times the host clock rate |
| rst_n | input | 1 | Asynchronous active-low reset (power-on) |
| sclk_i | input | 1 | Host serial clock, asynchronous |
| res_i | input | DATA_W | Conversion result from the core, two's complement |
| res_done_i | input | 1 | One-cycle pulse: res_i holds a new result |
| rdy_dout_o | output | 1 | Shared ready / serial data line |
| conv_start_o | output | 1 | One-cycle request to start a conversion |
| cal_start_o | output | 1 | One-cycle request to start a self-calibration |
| sleep_o | output | 1 | Level: core is asleep |

## Verification
The assertions assume that the core's done pulse lasts one cycle and that each host clock phase lasts longer than the synchroniser latency. They also assume that ordinary host clock high phases are shorter than HOLD_CYC, so that a sleep request is always deliberate. The bench holds each host clock phase for 8 system clocks against a 64-cycle timeout. It applies long high periods only when testing sleep or its absence, and pulses the done input for exactly one cycle, between host pulses.

// File: rtl/twr_pkg.sv
package twr_pkg;

    localparam int unsigned REL_PULSE = 25;
    localparam int unsigned CAL_PULSE = 26;
    localparam int unsigned PULSE_W   = $clog2(CAL_PULSE + 1);

    typedef enum logic [1:0] {
        ST_INIT  = 2'd0,
        ST_BUSY  = 2'd1,
        ST_FRAME = 2'd2,
        ST_SLEEP = 2'd3
    } twr_state_e;

endpackage

// File: rtl/twr_sclk_sync.sv
module twr_sclk_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_i,
    output logic sclk_lvl_o,
    output logic sclk_rise_o,
    output logic sclk_fall_o
);
    // STAGES flops of synchronisation plus one history flop for edge detection
    logic [STAGES:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-1:0], sclk_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign sclk_lvl_o  = sh_q[STAGES-1];
    assign sclk_rise_o =  sh_q[STAGES-1] & ~sh_q[STAGES];
    assign sclk_fall_o = ~sh_q[STAGES-1] &  sh_q[STAGES];
endmodule

// File: rtl/twr_hold_timer.sv
module twr_hold_timer #(
    parameter int unsigned HOLD_CYC = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_lvl_i,
    output logic hold_hit_o
);
    localparam int unsigned CW = $clog2(HOLD_CYC + 1);
    localparam logic [CW-1:0] HOLD_V = CW'(HOLD_CYC);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (!sclk_lvl_i)          cnt_d = '0;
        else if (cnt_q != HOLD_V) cnt_d = cnt_q + CW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign hold_hit_o = (cnt_q == HOLD_V);
endmodule

// File: rtl/twr_frame_ctrl.sv
module twr_frame_ctrl
    import twr_pkg::*;
#(
    parameter int unsigned DATA_W = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_rise_i,
    input  logic              sclk_fall_i,
    input  logic              hold_hit_i,
    input  logic [DATA_W-1:0] res_i,
    input  logic              res_done_i,
    output logic              rdy_dout_o,
    output logic              conv_start_o,
    output logic              cal_start_o,
    output logic              sleep_o
);
    localparam logic [PULSE_W-1:0] DATA_CNT = PULSE_W'(DATA_W);
    localparam logic [PULSE_W-1:0] REL_CNT  = PULSE_W'(REL_PULSE);
    localparam logic [PULSE_W-1:0] CAL_CNT  = PULSE_W'(CAL_PULSE);

    typedef struct packed {
        twr_state_e          st;
        logic [DATA_W-1:0]   shr;
        logic [PULSE_W-1:0]  cnt;
        logic                cal_wake;
        logic                dout;
        logic                conv;
        logic                cal;
        logic                slp;
    } ctl_t;

    ctl_t d, q;

    always_comb begin
        d      = q;
        d.conv = 1'b0;
        d.cal  = 1'b0;
        unique case (q.st)
            ST_INIT: begin
                d.cal = 1'b1;          // startup calibration
                d.st  = ST_BUSY;
                if (res_done_i) begin
                    d.shr  = res_i;
                    d.cnt  = '0;
                    d.dout = 1'b0;
                    d.st   = ST_FRAME;
                end
            end
            ST_BUSY: begin
                if (res_done_i) begin
                    d.shr  = res_i;
                    d.cnt  = '0;
                    d.dout = 1'b0;
                    d.st   = ST_FRAME;
                end
            end
            ST_FRAME: begin
                if (hold_hit_i) begin
                    d.st       = ST_SLEEP;
                    d.slp      = 1'b1;
                    d.dout     = 1'b1;
                    d.cal_wake = (q.cnt == CAL_CNT);
                end else if (res_done_i) begin
                    d.shr  = res_i;
                    d.cnt  = '0;
                    d.dout = 1'b0;
                end else if (sclk_rise_i) begin
                    if (q.cnt != CAL_CNT) d.cnt = q.cnt + PULSE_W'(1);
                    if (q.cnt < DATA_CNT) begin
                        d.dout = q.shr[DATA_W-1];
                        d.shr  = {q.shr[DATA_W-2:0], 1'b0};
                    end else if (q.cnt == REL_CNT - PULSE_W'(1)) begin
                        d.dout = 1'b1;
                    end
                end else if (sclk_fall_i && (q.cnt == CAL_CNT)) begin
                    d.cal  = 1'b1;
                    d.dout = 1'b1;
                    d.st   = ST_BUSY;
                end
            end
            ST_SLEEP: begin
                if (sclk_fall_i) begin
                    d.slp      = 1'b0;
                    d.st       = ST_BUSY;
                    d.cal_wake = 1'b0;
                    if (q.cal_wake) d.cal  = 1'b1;
                    else            d.conv = 1'b1;
                end
            end
            default: d.st = ST_BUSY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q          <= '0;
            q.st       <= ST_INIT;
            q.dout     <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign rdy_dout_o   = q.dout;
    assign conv_start_o = q.conv;
    assign cal_start_o  = q.cal;
    assign sleep_o      = q.slp;
endmodule

// File: rtl/twr_readout_top.sv
module twr_readout_top #(
    parameter int unsigned DATA_W   = 18,
    parameter int unsigned SYNC_STG = 2,
    parameter int unsigned HOLD_CYC = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_i,
    input  logic [DATA_W-1:0] res_i,
    input  logic              res_done_i,
    output logic              rdy_dout_o,
    output logic              conv_start_o,
    output logic              cal_start_o,
    output logic              sleep_o
);
    logic sclk_lvl, sclk_rise, sclk_fall, hold_hit;

    twr_sclk_sync #(.STAGES(SYNC_STG)) sync_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .sclk_i      (sclk_i),
        .sclk_lvl_o  (sclk_lvl),
        .sclk_rise_o (sclk_rise),
        .sclk_fall_o (sclk_fall)
    );

    twr_hold_timer #(.HOLD_CYC(HOLD_CYC)) hold_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .sclk_lvl_i (sclk_lvl),
        .hold_hit_o (hold_hit)
    );

    twr_frame_ctrl #(.DATA_W(DATA_W)) ctl_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .sclk_rise_i  (sclk_rise),
        .sclk_fall_i  (sclk_fall),
        .hold_hit_i   (hold_hit),
        .res_i        (res_i),
        .res_done_i   (res_done_i),
        .rdy_dout_o   (rdy_dout_o),
        .conv_start_o (conv_start_o),
        .cal_start_o  (cal_start_o),
        .sleep_o      (sleep_o)
    );
endmodule

// File: rtl/twr_readout_chk.sv
module twr_readout_chk (
    input logic clk,
    input logic rst_n,
    input logic res_done_i,
    input logic rdy_dout_o,
    input logic conv_start_o,
    input logic cal_start_o,
    input logic sleep_o,
    input logic hold_hit
);
    // R8: line driven high throughout sleep
    a_r8_line_high_asleep: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_o |-> rdy_dout_o);

    // R9: sleep is left only through a start request
    a_r9_wake_starts: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_o |=> (sleep_o || conv_start_o || cal_start_o));

    // R9: conversion requests only follow sleep
    a_r9_conv_after_sleep: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start_o |-> $past(sleep_o));

    // R2: an accepted result pulls the line low
    a_r2_ready_low: assert property (@(posedge clk) disable iff (!rst_n)
        (res_done_i && !sleep_o && !hold_hit) |=> !rdy_dout_o);

    // R12: requests never overlap and last one cycle
    a_r12_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(cal_start_o && conv_start_o));
    a_r12_cal_single: assert property (@(posedge clk) disable iff (!rst_n)
        cal_start_o |=> !cal_start_o);
    a_r12_conv_single: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start_o |=> !conv_start_o);
endmodule

bind twr_readout_top twr_readout_chk chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .res_done_i   (res_done_i),
    .rdy_dout_o   (rdy_dout_o),
    .conv_start_o (conv_start_o),
    .cal_start_o  (cal_start_o),
    .sleep_o      (sleep_o),
    .hold_hit     (hold_hit)
);

// File: tb/twr_readout_top_tb_top.sv
`timescale 1ns/1ps
module twr_readout_top_tb_top;
    localparam int DATA_W = 18;
    localparam int HALF   = 8;
    localparam int HOLD   = 64;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk_i = 1'b0;
    logic [DATA_W-1:0] res_i = '0;
    logic res_done_i = 1'b0;
    logic rdy_dout_o, conv_start_o, cal_start_o, sleep_o;

    int checks = 0;
    int errors = 0;
    int cal_n = 0, conv_n = 0, overlap_n = 0, wide_n = 0;
    logic cal_prev = 1'b0, conv_prev = 1'b0;

    logic  exp_q[$];
    string tag_q[$];

    always #2 clk = ~clk;

    twr_readout_top #(.DATA_W(DATA_W), .SYNC_STG(2), .HOLD_CYC(HOLD)) dut_i (
        .clk(clk), .rst_n(rst_n), .sclk_i(sclk_i), .res_i(res_i),
        .res_done_i(res_done_i), .rdy_dout_o(rdy_dout_o),
        .conv_start_o(conv_start_o), .cal_start_o(cal_start_o), .sleep_o(sleep_o)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // request pulse monitor (R1, R6, R9, R10, R12)
    always @(posedge clk) begin
        if (rst_n) begin
            if (cal_start_o)  cal_n  <= cal_n + 1;
            if (conv_start_o) conv_n <= conv_n + 1;
            if (cal_start_o && conv_start_o) overlap_n <= overlap_n + 1;
            if ((cal_start_o && cal_prev) || (conv_start_o && conv_prev)) wide_n <= wide_n + 1;
        end
        cal_prev  <= cal_start_o;
        conv_prev <= conv_start_o;
    end

    // scoreboard monitor: compares the line against queued expectations
    always @(negedge clk) begin
        if (exp_q.size() != 0) begin
            logic  e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(t, int'(rdy_dout_o), int'(e));
        end
    end

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic give(input logic [DATA_W-1:0] v);
        res_i = v;
        res_done_i = 1'b1;
        tick(1);
        res_done_i = 1'b0;
    endtask

    task automatic pulse_exp(input logic e, input string tag);
        sclk_i = 1'b1;
        tick(HALF);
        exp_q.push_back(e);
        tag_q.push_back(tag);
        sclk_i = 1'b0;
        tick(HALF);
    endtask

    task automatic pulse_nc();
        sclk_i = 1'b1;
        tick(HALF);
        sclk_i = 1'b0;
        tick(HALF);
    endtask

    task automatic read_word(input logic [DATA_W-1:0] v, input string tag);
        for (int i = DATA_W - 1; i >= 0; i--) pulse_exp(v[i], tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int c0, v0;
        logic [DATA_W-1:0] wa, wb, wc, wd, we;
        wa = 18'h2A5C3; wb = 18'h0F0F1; wc = 18'h15AA5; wd = 18'h33333; we = 18'h00C3C;

        tick(3);
        check("R1 line in reset", int'(rdy_dout_o), 1);
        check("R1 sleep in reset", int'(sleep_o), 0);
        rst_n = 1'b1;
        tick(10);
        check("R1 startup cal pulses", cal_n, 1);
        check("R1 no conv after reset", conv_n, 0);
        check("R1 line high before result", int'(rdy_dout_o), 1);

        // R2 / R3 / R4 / R5 / R6
        give(wa);
        tick(2);
        check("R2 line low on result", int'(rdy_dout_o), 0);
        tick(20);
        check("R2 line held low", int'(rdy_dout_o), 0);
        read_word(wa, "R3 data bit");
        for (int k = 0; k < 6; k++) pulse_exp(wa[0], "R4 pulses 19-24");
        pulse_exp(1'b1, "R5 25th pulse high");
        c0 = cal_n;
        pulse_nc();
        check("R6 26th fall cal", cal_n, c0 + 1);
        for (int k = 0; k < 4; k++) pulse_exp(1'b1, "R6 pulses ignored busy");
        check("R6 no extra cal", cal_n, c0 + 1);
        sclk_i = 1'b1;
        tick(3 * HOLD);
        check("R11 no sleep while busy", int'(sleep_o), 0);
        sclk_i = 1'b0;
        tick(HALF);

        // R7 overwrite, R4 idle at last bit
        give(wb);
        for (int i = DATA_W - 1; i >= DATA_W - 5; i--) pulse_exp(wb[i], "R3 partial read");
        give(wc);
        tick(2);
        check("R7 line low after overwrite", int'(rdy_dout_o), 0);
        read_word(wc, "R7 new word bits");
        tick(50);
        check("R4 idle at last bit", int'(rdy_dout_o), int'(wc[0]));

        // R8 / R9 sleep with plain wake
        give(wd);
        for (int i = DATA_W - 1; i >= DATA_W - 3; i--) pulse_exp(wd[i], "R3 bits before sleep");
        sclk_i = 1'b1;
        tick(HOLD + 20);
        check("R8 sleep entered", int'(sleep_o), 1);
        check("R8 line high asleep", int'(rdy_dout_o), 1);
        give(we);
        tick(4);
        check("R8 result ignored asleep", int'(rdy_dout_o), 1);
        c0 = cal_n; v0 = conv_n;
        sclk_i = 1'b0;
        tick(HALF);
        check("R9 sleep cleared", int'(sleep_o), 0);
        check("R9 conv on wake", conv_n, v0 + 1);
        check("R9 no cal on plain wake", cal_n, c0);
        check("R9 line high after wake", int'(rdy_dout_o), 1);

        // R10 sleep on 26th pulse
        give(we);
        read_word(we, "R3 data bit");
        for (int k = 0; k < 6; k++) pulse_nc();
        pulse_exp(1'b1, "R5 25th pulse high");
        sclk_i = 1'b1;
        tick(HOLD + 20);
        check("R10 sleep on 26th hold", int'(sleep_o), 1);
        c0 = cal_n; v0 = conv_n;
        sclk_i = 1'b0;
        tick(HALF);
        check("R10 cal on wake", cal_n, c0 + 1);
        check("R10 no conv on wake", conv_n, v0);

        tick(4);
        check("R12 no overlap", overlap_n, 0);
        check("R12 single-cycle pulses", wide_n, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule